// File: doc/BRIEF.md
# Ring Buffer Address Accelerator

This block keeps the state of several circular rings that live in external memory and turns accesses to a fixed per-ring address window into accesses to the right ring element. A write that lands in a ring's window is sent to that ring's tail element. A read is sent to its head element. Producers and consumers never track base addresses or offsets themselves. Because the head, tail and occupancy of every ring are held only here, any number of requesters can share one ring and still see the same state.

Each ring has its own set of registers. Software uses them to set the base address, the element size (a power of two bytes), the element count and the ring mode. Software can also reset a ring, or write a doorbell count that adds straight to the ring's occupancy. A write port and a read port may each present one access per clock. The block answers each access one cycle later with the translated memory address or an error flag. It also shows the occupancy of every ring as a flat output vector.

Top module: `ring_addr_xlate`

## Requirements
- R1: The ring of an access is chosen by access address bits [14:12] (ring index above a 12-bit window). The low 12 window bits have no effect on the result.
- R2: An accepted write returns the address base + tail * 2^size. The tail then advances by one and goes back to 0 when it reaches the element count.
- R3: An accepted read returns the address base + head * 2^size. The head then advances by one and goes back to 0 when it reaches the element count.
- R4: Every access is answered on its response port in the cycle after it is presented, with valid set and the error flag. On an error the response address is zero.
- R5: In ring mode (mode code 0), a doorbell write of N adds N to that ring's occupancy in one step. In any other mode the doorbell leaves occupancy unchanged.
- R6: A doorbell value above 127 is rejected. Occupancy stays the same and reg_err is high for one cycle in the next cycle. Accepted register writes leave reg_err low.
- R7: Occupancy is 21 bits wide and wraps modulo 2^21.
- R8: A write to a full ring (occupancy >= element count) returns an error. A read from an empty ring (occupancy 0) returns an error. Neither changes the ring's state.
- R9: A ring with element count 0 answers every access with an error.
- R10: A read and a write to the same ring in the same cycle are ordered write first. On an empty ring the read succeeds and returns the element just written. Occupancy changes by the net count.
- R11: Writing bit 0 = 1 to a ring's control field clears its head, tail and occupancy and keeps its configuration. An access to that ring in the same cycle gets an error.
- R12: Register address = {ring[2:0], field[1:0]}. Field 0 is the base address. Field 1 is the configuration: count in bits [15:0], size log2 in bits [18:16], mode in bits [21:20]. Field 2 is the doorbell. Field 3 is the control field.
- R13: Rings are independent. Accesses to two different rings in one cycle are both served, and an access never changes another ring's state.
- R14: After reset, no response is valid, reg_err is low and every occupancy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_wr_valid | input | 1 | Write access present |
| acc_wr_addr | input | 15 | Write access address: ring index and window offset |
| acc_rd_valid | input | 1 | Read access present |
| acc_rd_addr | input | 15 | Read access address: ring index and window offset |
| wr_rsp_valid | output | 1 | Write response, one cycle after the access |
| wr_rsp_err | output | 1 | Write refused |
| wr_rsp_addr | output | 32 | Translated tail element address |
| rd_rsp_valid | output | 1 | Read response, one cycle after the access |
| rd_rsp_err | output | 1 | Read refused |
| rd_rsp_addr | output | 32 | Translated head element address |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address {ring, field} |
| reg_wdata | input | 32 | Register write data |
| reg_err | output | 1 | Rejected doorbell, one cycle after the write |
| ring_occ | output | 168 | Occupancy of ring r in bits [r*21 +: 21] |

## Verification
The assertions take two things for granted. First, register writes and accesses arrive only after the internal reset has been released. Second, element count, size and mode are not changed while a ring holds live elements, so the head and tail stay below the count. The stimulus therefore configures each ring once before it is used, and changes the mode of a ring only when that ring is empty. The occupancy wrap is reached the lawful way, through a long run of doorbell writes each at or under the limit, and not by forcing state.

// File: rtl/rax_pkg.sv
package rax_pkg;

  // Layout of the configuration register, shared by decode and ring slots
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned SZ_W   = 3;

  typedef enum logic [1:0] {
    MODE_RING  = 2'd0,
    MODE_MSG   = 2'd1,
    MODE_AUX_A = 2'd2,
    MODE_AUX_B = 2'd3
  } ring_mode_e;

  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_CFG   = 2'd1,
    FLD_DBELL = 2'd2,
    FLD_CTRL  = 2'd3
  } reg_field_e;

  typedef struct packed {
    ring_mode_e             mode;
    logic [SZ_W-1:0]        size_log2;
    logic [CNT_W-1:0]       count;
  } ring_cfg_t;

endpackage

// File: rtl/rax_reg_decode.sv
module rax_reg_decode
  import rax_pkg::*;
#(
  parameter int unsigned NUM_RINGS = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned OCC_W     = 21,
  parameter int unsigned DB_MAX    = 127,
  localparam int unsigned RIDX_W   = $clog2(NUM_RINGS),
  localparam int unsigned REG_AW   = RIDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [NUM_RINGS-1:0] base_we,
  output logic [NUM_RINGS-1:0] cfg_we,
  output logic [NUM_RINGS-1:0] db_we,
  output logic [NUM_RINGS-1:0] clr,
  output ring_cfg_t            cfg_d,
  output logic [OCC_W-1:0]     db_cnt,
  output logic                 reg_err
);

  logic [RIDX_W-1:0] ring_sel;
  reg_field_e        fld;
  logic              db_too_big;
  logic              err_d;
  logic              err_q;

  assign ring_sel   = reg_addr[2 +: RIDX_W];
  assign fld        = reg_field_e'(reg_addr[1:0]);
  assign db_too_big = reg_wdata > DATA_W'(DB_MAX);
  assign db_cnt     = reg_wdata[OCC_W-1:0];

  assign cfg_d.count     = reg_wdata[CNT_W-1:0];
  assign cfg_d.size_log2 = reg_wdata[16 +: SZ_W];
  assign cfg_d.mode      = ring_mode_e'(reg_wdata[21:20]);

  always_comb begin
    for (int r = 0; r < NUM_RINGS; r++) begin
      base_we[r] = reg_we && (ring_sel == RIDX_W'(r)) && (fld == FLD_BASE);
      cfg_we[r]  = reg_we && (ring_sel == RIDX_W'(r)) && (fld == FLD_CFG);
      db_we[r]   = reg_we && (ring_sel == RIDX_W'(r)) && (fld == FLD_DBELL) && !db_too_big;
      clr[r]     = reg_we && (ring_sel == RIDX_W'(r)) && (fld == FLD_CTRL) && reg_wdata[0];
    end
  end

  assign err_d = reg_we && (fld == FLD_DBELL) && db_too_big;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign reg_err = err_q;

  // R6: an oversized doorbell is flagged in the following cycle
  assert_db_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr[1:0] == 2'd2 && reg_wdata > DATA_W'(DB_MAX)) |=> reg_err);

  // R6: no flag without a register write the cycle before
  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> !reg_err);

endmodule

// File: rtl/rax_ring_slot.sv
module rax_ring_slot
  import rax_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OCC_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_d,
  input  logic              cfg_we,
  input  ring_cfg_t         cfg_d,
  input  logic              db_we,
  input  logic [OCC_W-1:0]  db_cnt,
  input  logic              clr,
  input  logic              wr_req,
  input  logic              rd_req,
  output logic              wr_grant,
  output logic              rd_grant,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [OCC_W-1:0]  occ
);

  logic [ADDR_W-1:0] base_q;
  ring_cfg_t         cfg_q;
  logic [CNT_W-1:0]  head_q, head_d;
  logic [CNT_W-1:0]  tail_q, tail_d;
  logic [OCC_W-1:0]  occ_q, occ_d;
  logic              live, is_full, is_empty, db_eff;
  logic              ptr_en, occ_en;

  function automatic logic [CNT_W-1:0] step_idx(input logic [CNT_W-1:0] idx,
                                                input logic [CNT_W-1:0] cnt);
    logic [CNT_W:0] nx;
    nx = {1'b0, idx} + (CNT_W+1)'(1);
    return (nx == {1'b0, cnt}) ? '0 : nx[CNT_W-1:0];
  endfunction

  assign live     = (cfg_q.count != '0) && !clr;
  assign is_full  = occ_q >= OCC_W'(cfg_q.count);
  assign is_empty = (occ_q == '0);
  assign db_eff   = db_we && (cfg_q.mode == MODE_RING);

  // write is served first, so a same-cycle write can feed a read on an empty ring
  assign wr_grant = wr_req && live && !is_full;
  assign rd_grant = rd_req && live && (!is_empty || wr_grant);

  assign wr_addr = base_q + (ADDR_W'(tail_q) << cfg_q.size_log2);
  assign rd_addr = base_q + (ADDR_W'(head_q) << cfg_q.size_log2);
  assign occ     = occ_q;

  assign ptr_en = clr || wr_grant || rd_grant;
  assign occ_en = ptr_en || db_eff;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    occ_d  = occ_q + OCC_W'(wr_grant) - OCC_W'(rd_grant);
    if (db_eff)   occ_d  = occ_d + db_cnt;
    if (wr_grant) tail_d = step_idx(tail_q, cfg_q.count);
    if (rd_grant) head_d = step_idx(head_q, cfg_q.count);
    if (clr) begin
      head_d = '0;
      tail_d = '0;
      occ_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (base_we) base_q <= base_d;
      if (cfg_we)  cfg_q  <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (ptr_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ_q <= '0;
    else if (occ_en) occ_q <= occ_d;
  end

  // R11: a ring reset leaves head, tail and occupancy at zero
  assert_ring_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (occ_q == '0 && head_q == '0 && tail_q == '0));

  // R8: a refused access changes nothing
  assert_refused_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_req || rd_req) && !wr_grant && !rd_grant && !db_eff && !clr)
      |=> ($stable(occ_q) && $stable(head_q) && $stable(tail_q)));

  // R5: a lone ring-mode doorbell adds its count to occupancy
  assert_db_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (db_eff && !clr && !wr_grant && !rd_grant)
      |=> occ_q == $past(occ_q) + $past(db_cnt));

  // R5: a doorbell outside ring mode leaves occupancy alone
  assert_db_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (db_we && cfg_q.mode != MODE_RING && !clr && !wr_grant && !rd_grant)
      |=> $stable(occ_q));

  // R2: the tail moves by one or wraps to zero
  assert_tail_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_grant && !clr) |=> (tail_q == '0 || tail_q == $past(tail_q) + CNT_W'(1)));

endmodule

// File: rtl/rax_access_port.sv
module rax_access_port #(
  parameter int unsigned NUM_RINGS = 8,
  parameter int unsigned WIN_W     = 12,
  parameter int unsigned ADDR_W    = 32,
  localparam int unsigned RIDX_W   = $clog2(NUM_RINGS),
  localparam int unsigned ACC_AW   = WIN_W + RIDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_wr_valid,
  input  logic [ACC_AW-1:0]    acc_wr_addr,
  input  logic                 acc_rd_valid,
  input  logic [ACC_AW-1:0]    acc_rd_addr,
  input  logic [NUM_RINGS-1:0] wr_grant,
  input  logic [NUM_RINGS-1:0] rd_grant,
  input  logic [ADDR_W-1:0]    wr_addr_v [NUM_RINGS],
  input  logic [ADDR_W-1:0]    rd_addr_v [NUM_RINGS],
  output logic [NUM_RINGS-1:0] wr_req,
  output logic [NUM_RINGS-1:0] rd_req,
  output logic                 wr_rsp_valid,
  output logic                 wr_rsp_err,
  output logic [ADDR_W-1:0]    wr_rsp_addr,
  output logic                 rd_rsp_valid,
  output logic                 rd_rsp_err,
  output logic [ADDR_W-1:0]    rd_rsp_addr
);

  logic [RIDX_W-1:0] wr_ring, rd_ring;
  logic              wr_ok, rd_ok;
  logic [ADDR_W-1:0] wr_a_d, rd_a_d;
  logic              unused_window;

  assign wr_ring = acc_wr_addr[WIN_W +: RIDX_W];
  assign rd_ring = acc_rd_addr[WIN_W +: RIDX_W];
  assign unused_window = ^{acc_wr_addr[WIN_W-1:0], acc_rd_addr[WIN_W-1:0]};

  always_comb begin
    for (int r = 0; r < NUM_RINGS; r++) begin
      wr_req[r] = acc_wr_valid && (wr_ring == RIDX_W'(r));
      rd_req[r] = acc_rd_valid && (rd_ring == RIDX_W'(r));
    end
  end

  assign wr_ok  = wr_grant[wr_ring];
  assign rd_ok  = rd_grant[rd_ring];
  assign wr_a_d = wr_ok ? wr_addr_v[wr_ring] : '0;
  assign rd_a_d = rd_ok ? rd_addr_v[rd_ring] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_rsp_valid <= 1'b0;
      rd_rsp_valid <= 1'b0;
    end else begin
      wr_rsp_valid <= acc_wr_valid;
      rd_rsp_valid <= acc_rd_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_rsp_err  <= 1'b0;
      wr_rsp_addr <= '0;
    end else if (acc_wr_valid) begin
      wr_rsp_err  <= !wr_ok;
      wr_rsp_addr <= wr_a_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_rsp_err  <= 1'b0;
      rd_rsp_addr <= '0;
    end else if (acc_rd_valid) begin
      rd_rsp_err  <= !rd_ok;
      rd_rsp_addr <= rd_a_d;
    end
  end

  // R4: each access is answered exactly one cycle later
  assert_wr_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr_valid |=> wr_rsp_valid);
  assert_rd_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd_valid |=> !rd_rsp_valid);
  // R4: a refused access carries a zero address
  assert_err_zero_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rsp_valid && wr_rsp_err) |-> wr_rsp_addr == '0);

endmodule

// File: rtl/ring_addr_xlate.sv
module ring_addr_xlate
  import rax_pkg::*;
#(
  parameter int unsigned NUM_RINGS = 8,
  parameter int unsigned WIN_W     = 12,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned OCC_W     = 21,
  parameter int unsigned DB_MAX    = 127,
  localparam int unsigned RIDX_W   = $clog2(NUM_RINGS),
  localparam int unsigned ACC_AW   = WIN_W + RIDX_W,
  localparam int unsigned REG_AW   = RIDX_W + 2,
  localparam int unsigned DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_wr_valid,
  input  logic [ACC_AW-1:0]          acc_wr_addr,
  input  logic                       acc_rd_valid,
  input  logic [ACC_AW-1:0]          acc_rd_addr,
  output logic                       wr_rsp_valid,
  output logic                       wr_rsp_err,
  output logic [ADDR_W-1:0]          wr_rsp_addr,
  output logic                       rd_rsp_valid,
  output logic                       rd_rsp_err,
  output logic [ADDR_W-1:0]          rd_rsp_addr,
  input  logic                       reg_we,
  input  logic [REG_AW-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic                       reg_err,
  output logic [NUM_RINGS*OCC_W-1:0] ring_occ
);

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic [NUM_RINGS-1:0] base_we, cfg_we, db_we, clr;
  ring_cfg_t            cfg_d;
  logic [OCC_W-1:0]     db_cnt;
  logic [NUM_RINGS-1:0] wr_req, rd_req, wr_grant, rd_grant;
  logic [ADDR_W-1:0]    wr_addr_v [NUM_RINGS];
  logic [ADDR_W-1:0]    rd_addr_v [NUM_RINGS];
  logic [OCC_W-1:0]     occ_v     [NUM_RINGS];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rax_reg_decode #(
    .NUM_RINGS(NUM_RINGS), .DATA_W(DATA_W), .OCC_W(OCC_W), .DB_MAX(DB_MAX)
  ) u_decode (
    .clk(clk), .rst_n(rst_int_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .base_we(base_we), .cfg_we(cfg_we), .db_we(db_we), .clr(clr),
    .cfg_d(cfg_d), .db_cnt(db_cnt), .reg_err(reg_err)
  );

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    rax_ring_slot #(.ADDR_W(ADDR_W), .OCC_W(OCC_W)) u_slot (
      .clk(clk), .rst_n(rst_int_n),
      .base_we(base_we[r]), .base_d(reg_wdata[ADDR_W-1:0]),
      .cfg_we(cfg_we[r]), .cfg_d(cfg_d),
      .db_we(db_we[r]), .db_cnt(db_cnt), .clr(clr[r]),
      .wr_req(wr_req[r]), .rd_req(rd_req[r]),
      .wr_grant(wr_grant[r]), .rd_grant(rd_grant[r]),
      .wr_addr(wr_addr_v[r]), .rd_addr(rd_addr_v[r]),
      .occ(occ_v[r])
    );
    assign ring_occ[r*OCC_W +: OCC_W] = occ_v[r];
  end

  rax_access_port #(
    .NUM_RINGS(NUM_RINGS), .WIN_W(WIN_W), .ADDR_W(ADDR_W)
  ) u_access (
    .clk(clk), .rst_n(rst_int_n),
    .acc_wr_valid(acc_wr_valid), .acc_wr_addr(acc_wr_addr),
    .acc_rd_valid(acc_rd_valid), .acc_rd_addr(acc_rd_addr),
    .wr_grant(wr_grant), .rd_grant(rd_grant),
    .wr_addr_v(wr_addr_v), .rd_addr_v(rd_addr_v),
    .wr_req(wr_req), .rd_req(rd_req),
    .wr_rsp_valid(wr_rsp_valid), .wr_rsp_err(wr_rsp_err), .wr_rsp_addr(wr_rsp_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_err(rd_rsp_err), .rd_rsp_addr(rd_rsp_addr)
  );

  // R13: grants only go to the ring that was addressed
  assert_single_grant_R13: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(wr_grant) && $onehot0(rd_grant));

endmodule

// File: tb/ring_addr_xlate_bench.sv
`timescale 1ns/1ps
module ring_addr_xlate_bench;

  logic         clk;
  logic         rst_n;
  logic         acc_wr_valid, acc_rd_valid;
  logic [14:0]  acc_wr_addr, acc_rd_addr;
  logic         wr_rsp_valid, wr_rsp_err, rd_rsp_valid, rd_rsp_err;
  logic [31:0]  wr_rsp_addr, rd_rsp_addr;
  logic         reg_we;
  logic [4:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic         reg_err;
  logic [167:0] ring_occ;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  ring_addr_xlate u_ring_addr_xlate (
    .clk(clk), .rst_n(rst_n),
    .acc_wr_valid(acc_wr_valid), .acc_wr_addr(acc_wr_addr),
    .acc_rd_valid(acc_rd_valid), .acc_rd_addr(acc_rd_addr),
    .wr_rsp_valid(wr_rsp_valid), .wr_rsp_err(wr_rsp_err), .wr_rsp_addr(wr_rsp_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_err(rd_rsp_err), .rd_rsp_addr(rd_rsp_addr),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_err(reg_err), .ring_occ(ring_occ)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        wv;
    logic [2:0]  wring;
    logic        rv;
    logic [2:0]  rring;
    logic        wexp_err;
    logic [31:0] wexp_addr;
    logic        rexp_err;
    logic [31:0] rexp_addr;
  } vec_t;

  // ring 2: base 0x1000_0000, 8-byte elements, 3 elements
  // ring 5: base 0x2000_0400, 16-byte elements, 2 elements
  localparam vec_t VECS [14] = '{
    '{1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 32'h1000_0000, 1'b0, 32'h0},
    '{1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 32'h1000_0008, 1'b0, 32'h0},
    '{1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 32'h0,         1'b0, 32'h1000_0000},
    '{1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 32'h1000_0010, 1'b0, 32'h0},
    '{1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 32'h1000_0000, 1'b0, 32'h0},
    '{1'b1, 3'd2, 1'b0, 3'd0, 1'b1, 32'h0,         1'b0, 32'h0},
    '{1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 32'h0,         1'b0, 32'h1000_0008},
    '{1'b1, 3'd5, 1'b1, 3'd2, 1'b0, 32'h2000_0400, 1'b0, 32'h1000_0010},
    '{1'b1, 3'd2, 1'b1, 3'd5, 1'b0, 32'h1000_0008, 1'b0, 32'h2000_0400},
    '{1'b0, 3'd0, 1'b1, 3'd5, 1'b0, 32'h0,         1'b1, 32'h0},
    '{1'b1, 3'd5, 1'b1, 3'd5, 1'b0, 32'h2000_0410, 1'b0, 32'h2000_0410},
    '{1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 32'h0,         1'b0, 32'h1000_0000},
    '{1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 32'h0,         1'b0, 32'h1000_0008},
    '{1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 32'h0,         1'b1, 32'h0}
  };

  function automatic logic [20:0] occ_of(input int r);
    return ring_occ[r*21 +: 21];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge with results registered
  task automatic reg_write(input logic [2:0] ring, input logic [1:0] fld, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = {ring, fld}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic access(input logic wv, input logic [2:0] wr, input logic rv,
                        input logic [2:0] rr, input logic [11:0] off);
    acc_wr_valid = wv; acc_wr_addr = {wr, off};
    acc_rd_valid = rv; acc_rd_addr = {rr, ~off};
    @(negedge clk);
    acc_wr_valid = 1'b0; acc_rd_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    acc_wr_valid = 1'b0; acc_rd_valid = 1'b0;
    acc_wr_addr = '0; acc_rd_addr = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R14: reset state
    check("R14 wr_rsp_valid", 64'(wr_rsp_valid), 64'd0);
    check("R14 rd_rsp_valid", 64'(rd_rsp_valid), 64'd0);
    check("R14 reg_err", 64'(reg_err), 64'd0);
    check("R14 ring_occ", 64'(|ring_occ), 64'd0);

    // R12: configuration through the register map
    reg_write(3'd2, 2'd0, 32'h1000_0000);
    reg_write(3'd2, 2'd1, (32'd3 << 16) | 32'd3);
    reg_write(3'd5, 2'd0, 32'h2000_0400);
    reg_write(3'd5, 2'd1, (32'd4 << 16) | 32'd2);
    reg_write(3'd3, 2'd0, 32'h3000_0000);
    reg_write(3'd3, 2'd1, 32'd1);
    access(1'b1, 3'd3, 1'b0, 3'd0, 12'h123);
    check("R12 ring3 base element", {31'd0, wr_rsp_err, wr_rsp_addr}, {31'd0, 1'b0, 32'h3000_0000});
    access(1'b1, 3'd3, 1'b0, 3'd0, 12'h456);
    check("R12 ring3 count one full", 64'(wr_rsp_err), 64'd1);

    // main table: R1 R2 R3 R4 R8 R10 R13
    for (int i = 0; i < 14; i++) begin
      access(VECS[i].wv, VECS[i].wring, VECS[i].rv, VECS[i].rring, 12'(i * 293 + 7));
      check($sformatf("R4 vec%0d wr valid", i), 64'(wr_rsp_valid), 64'(VECS[i].wv));
      check($sformatf("R4 vec%0d rd valid", i), 64'(rd_rsp_valid), 64'(VECS[i].rv));
      if (VECS[i].wv)
        check($sformatf("R1/R2/R8/R10/R13 vec%0d write", i), {31'd0, wr_rsp_err, wr_rsp_addr},
              {31'd0, VECS[i].wexp_err, VECS[i].wexp_addr});
      if (VECS[i].rv)
        check($sformatf("R1/R3/R8/R10/R13 vec%0d read", i), {31'd0, rd_rsp_err, rd_rsp_addr},
              {31'd0, VECS[i].rexp_err, VECS[i].rexp_addr});
    end
    check("R13 ring2 occ after table", 64'(occ_of(2)), 64'd0);
    check("R13 ring5 occ after table", 64'(occ_of(5)), 64'd0);
    check("R13 ring3 occ untouched", 64'(occ_of(3)), 64'd1);

    // R9: unconfigured ring 0 refuses everything
    access(1'b1, 3'd0, 1'b1, 3'd0, 12'h0);
    check("R9 count zero write", 64'(wr_rsp_err), 64'd1);
    check("R9 count zero read", 64'(rd_rsp_err), 64'd1);

    // R5: doorbell in ring mode
    reg_write(3'd2, 2'd2, 32'd10);
    check("R5 doorbell adds", 64'(occ_of(2)), 64'd10);
    check("R6 accepted doorbell no err", 64'(reg_err), 64'd0);
    access(1'b1, 3'd2, 1'b0, 3'd0, 12'h0);
    check("R8 write past count refused", 64'(wr_rsp_err), 64'd1);
    access(1'b0, 3'd0, 1'b1, 3'd2, 12'h0);
    check("R3 read after doorbell", {31'd0, rd_rsp_err, rd_rsp_addr}, {31'd0, 1'b0, 32'h1000_0010});
    check("R3 occ after read", 64'(occ_of(2)), 64'd9);

    // R5: doorbell ignored outside ring mode
    reg_write(3'd5, 2'd1, (32'd1 << 20) | (32'd4 << 16) | 32'd2);
    reg_write(3'd5, 2'd2, 32'd4);
    check("R5 non-ring mode doorbell ignored", 64'(occ_of(5)), 64'd0);

    // R6: oversized doorbell rejected
    reg_write(3'd2, 2'd2, 32'd128);
    check("R6 oversized flag", 64'(reg_err), 64'd1);
    check("R6 oversized no change", 64'(occ_of(2)), 64'd9);
    reg_write(3'd2, 2'd2, 32'd127);
    check("R6 maximum accepted flag", 64'(reg_err), 64'd0);
    check("R6 maximum accepted occ", 64'(occ_of(2)), 64'd136);

    // R11: ring reset with a concurrent read
    reg_we = 1'b1; reg_addr = {3'd2, 2'd3}; reg_wdata = 32'd1;
    acc_rd_valid = 1'b1; acc_rd_addr = {3'd2, 12'hFFF};
    @(negedge clk);
    reg_we = 1'b0; acc_rd_valid = 1'b0;
    check("R11 access during reset refused", 64'(rd_rsp_err), 64'd1);
    check("R11 occ cleared", 64'(occ_of(2)), 64'd0);
    access(1'b1, 3'd2, 1'b0, 3'd0, 12'h010);
    check("R11 tail back at base", {31'd0, wr_rsp_err, wr_rsp_addr}, {31'd0, 1'b0, 32'h1000_0000});
    access(1'b1, 3'd2, 1'b0, 3'd0, 12'h020);
    check("R2 second element", {31'd0, wr_rsp_err, wr_rsp_addr}, {31'd0, 1'b0, 32'h1000_0008});

    // R7: drive occupancy round the 21-bit wrap with legal doorbells
    begin
      int rem;
      int bad;
      bool_first: begin end
      rem = (1 << 21) - 2;
      bad = 0;
      reg_write(3'd2, 2'd2, 32'd127);
      rem -= 127;
      check("R7 occ partway", 64'(occ_of(2)), 64'd129);
      while (rem > 0) begin
        int n;
        n = (rem > 127) ? 127 : rem;
        reg_write(3'd2, 2'd2, 32'(n));
        if (reg_err) bad++;
        rem -= n;
      end
      check("R6 no flag during run", 64'(bad), 64'd0);
    end
    check("R7 occ wrapped to zero", 64'(occ_of(2)), 64'd0);
    access(1'b0, 3'd0, 1'b1, 3'd2, 12'h0);
    check("R8 empty after wrap", 64'(rd_rsp_err), 64'd1);
    check("R8 occ kept after refusal", 64'(occ_of(2)), 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule